// File: doc/BRIEF.md
# Configurable 3-Wire RF Register Serializer

This block sends one register write to an RF front-end over three wires: a serial data line, a serial clock and a latch-enable strobe. The host presents a type code, a register address and a data word together with a one-cycle command strobe. That strobe acts as setting the poll bit. The block builds the frame that matches the selected RF type, picks the frame length and shift direction, and produces the serial waveform. It then clears the poll bit by itself once the latch strobe has been given and the line has recovered.

Four type codes are supported. Code 2 scrambles its fields by reversing the bit order of every nibble. A type code the block does not know is refused with a one-cycle error pulse, and the wires stay idle. While a frame is in flight, further commands are ignored. The serial clock high and low times are set by parameters, counted in system clock cycles, and each must be at least 2.

Top module: `rf3w_serializer`

## Requirements
- R1: After reset, rf_clk, rf_data, rf_le, poll_busy and cmd_err are all 0.
- R2: Type code 0 sends 16 bits, most significant first, of the frame {data[11:0], addr[3:0]}.
- R3: Type code 1 sends 32 bits, least significant first, of the frame {data[23:0], 1'b1, addr[6:0]}, where bit 7 is the write-enable bit.
- R4: Type code 2 sends 22 bits, most significant first, of {1'b0, rv(data[15:12]), addr[0], rv(addr[4:1]), rv(data[3:0]), rv(data[7:4]), rv(data[11:8])}, where rv reverses the order of the 4 bits (0x1 becomes 0x8, 0x3 becomes 0xC).
- R5: Type code 3 sends 22 bits, most significant first, of the frame {data[17:0], addr[3:0]}.
- R6: Type codes 4 to 7 accepted while idle give a single-cycle cmd_err pulse in the next cycle. poll_busy stays 0 and no clock or latch activity appears.
- R7: Every rf_clk high phase lasts exactly HI_CYC cycles, and every low phase before a rising edge lasts at least LO_CYC cycles.
- R8: rf_data never changes while rf_clk is high, and never in the cycle rf_clk rises.
- R9: rf_le rises only after the last bit of the frame has been clocked. It is high only while rf_clk is low, stays high for exactly HI_CYC cycles, and falls before the next frame starts.
- R10: poll_busy is 1 in the cycle after an accepted command. It falls exactly LO_CYC cycles after rf_le falls. Commands given while poll_busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe (sets the poll bit) |
| cmd_type | input | 3 | RF type code |
| cmd_addr | input | 7 | Register address |
| cmd_data | input | 24 | Register data |
| poll_busy | output | 1 | Poll bit; clears itself when the transfer is done |
| cmd_err | output | 1 | One-cycle pulse for a refused type code |
| rf_data | output | 1 | Serial data |
| rf_clk | output | 1 | Serial clock |
| rf_le | output | 1 | Latch-enable strobe |

## Verification
A wrong frame builder shows as a captured bit string or bit count that differs from the model at the latch strobe, one frame after the command. A faulty phase counter or state register shows within a single bit period, as a clock phase of the wrong length, data moving while the clock is high, or a latch strobe that comes early or overlaps the clock. A poll bit that clears at the wrong time shows as an offset between the strobe falling and poll_busy falling, or as a second frame after a command that should have been ignored.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 24;
    localparam int FRAME_W = 32;
    localparam int NB_W    = 6;

    localparam logic [2:0] TYPE_A = 3'd0;
    localparam logic [2:0] TYPE_B = 3'd1;
    localparam logic [2:0] TYPE_C = 3'd2;
    localparam logic [2:0] TYPE_D = 3'd3;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
        logic               lsb_first;
        logic               known;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_LATCH,
        ST_RECOV
    } sh_state_e;

    function automatic logic [3:0] rev4(input logic [3:0] n);
        return {n[0], n[1], n[2], n[3]};
    endfunction

endpackage

// File: rtl/rf3w_framer.sv
module rf3w_framer
    import rf3w_pkg::*;
(
    input  logic [2:0]        rf_type,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output frame_t            frame
);

    localparam int NIBS = 4;

    logic [NIBS*4-1:0] drev;
    logic [3:0]        arev;

    // nibble-wise bit reversal of the low data half-word
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign drev[g*4 +: 4] = rev4(data[g*4 +: 4]);
    end

    assign arev = rev4(addr[4:1]);

    always_comb begin
        frame = '0;
        case (rf_type)
            TYPE_A: begin
                frame.bits[15:0] = {data[11:0], addr[3:0]};
                frame.nbits      = NB_W'(16);
                frame.lsb_first  = 1'b0;
                frame.known      = 1'b1;
            end
            TYPE_B: begin
                frame.bits       = {data[23:0], 1'b1, addr[6:0]};
                frame.nbits      = NB_W'(32);
                frame.lsb_first  = 1'b1;
                frame.known      = 1'b1;
            end
            TYPE_C: begin
                frame.bits[21:0] = {1'b0, drev[15:12], addr[0], arev,
                                    drev[3:0], drev[7:4], drev[11:8]};
                frame.nbits      = NB_W'(22);
                frame.lsb_first  = 1'b0;
                frame.known      = 1'b1;
            end
            TYPE_D: begin
                frame.bits[21:0] = {data[17:0], addr[3:0]};
                frame.nbits      = NB_W'(22);
                frame.lsb_first  = 1'b0;
                frame.known      = 1'b1;
            end
            default: begin
                frame.known      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rf3w_shifter.sv
module rf3w_shifter
    import rf3w_pkg::*;
#(
    parameter int HI_CYC = 4,
    parameter int LO_CYC = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  frame_t frame_i,
    output logic   busy,
    output logic   ser_clk,
    output logic   ser_data,
    output logic   ser_le
);

    localparam int CMAX  = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam logic [CNT_W-1:0] HI_LOAD = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LOAD = CNT_W'(LO_CYC - 1);

    typedef struct packed {
        sh_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [NB_W-1:0]    rem;
        logic [FRAME_W-1:0] sh;
        logic               lsb;
        logic               sclk;
        logic               sdat;
        logic               le;
    } sh_regs_t;

    sh_regs_t r_d, r_q;

    logic               go;
    logic [NB_W-1:0]    shamt;
    logic [FRAME_W-1:0] load_sh;
    logic [FRAME_W-1:0] next_sh;

    assign go    = start && frame_i.known && (r_q.st == ST_IDLE);
    assign shamt = NB_W'(FRAME_W) - frame_i.nbits;

    // MSB-first frames are left-aligned so the outgoing bit is always bit 31
    assign load_sh = frame_i.lsb_first ? frame_i.bits : (frame_i.bits << shamt);
    assign next_sh = r_q.lsb ? (r_q.sh >> 1) : (r_q.sh << 1);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.st   = ST_LOW;
                    r_d.cnt  = LO_LOAD;
                    r_d.sh   = load_sh;
                    r_d.lsb  = frame_i.lsb_first;
                    r_d.rem  = frame_i.nbits - NB_W'(1);
                    r_d.sdat = frame_i.lsb_first ? load_sh[0] : load_sh[FRAME_W-1];
                    r_d.sclk = 1'b0;
                    r_d.le   = 1'b0;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_HIGH;
                    r_d.cnt  = HI_LOAD;
                    r_d.sclk = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == '0) begin
                    r_d.sclk = 1'b0;
                    r_d.cnt  = LO_LOAD;
                    if (r_q.rem == '0) begin
                        r_d.st   = ST_TAIL;
                        r_d.sdat = 1'b0;
                    end else begin
                        r_d.st   = ST_LOW;
                        r_d.sh   = next_sh;
                        r_d.rem  = r_q.rem - NB_W'(1);
                        r_d.sdat = r_q.lsb ? next_sh[0] : next_sh[FRAME_W-1];
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_TAIL: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_LATCH;
                    r_d.cnt = HI_LOAD;
                    r_d.le  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_LATCH: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_RECOV;
                    r_d.cnt = LO_LOAD;
                    r_d.le  = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_RECOV: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign ser_clk  = r_q.sclk;
    assign ser_data = r_q.sdat;
    assign ser_le   = r_q.le;

    // ---------------- checker state ----------------
    logic [CNT_W:0]  hi_run_q;
    logic [NB_W:0]   edge_cnt_q;
    logic [NB_W-1:0] nb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q   <= '0;
            edge_cnt_q <= '0;
            nb_q       <= '0;
        end else begin
            hi_run_q <= ser_clk ? hi_run_q + (CNT_W+1)'(1) : '0;
            if (go) begin
                edge_cnt_q <= '0;
                nb_q       <= frame_i.nbits;
            end else if (r_d.sclk && !r_q.sclk) begin
                edge_cnt_q <= edge_cnt_q + (NB_W+1)'(1);
            end
        end
    end

    // R7: each high phase of the serial clock lasts HI_CYC cycles
    a_r7_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_clk && $past(ser_clk)) |-> (hi_run_q == (CNT_W+1)'(HI_CYC)));

    // R8: data holds while the clock is high and across its rising edge
    a_r8_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    a_r8_data_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    // R9: latch strobe only after every bit has been clocked, never with clock high
    a_r9_le_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> (edge_cnt_q == {1'b0, nb_q}));
    a_r9_le_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> !ser_clk);

    // R10: any wire activity happens only while the poll bit is set
    a_r10_active_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk || ser_le) |-> busy);

endmodule

// File: rtl/rf3w_serializer.sv
module rf3w_serializer
    import rf3w_pkg::*;
#(
    parameter int HI_CYC = 4,
    parameter int LO_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              poll_busy,
    output logic              cmd_err,
    output logic              rf_data,
    output logic              rf_clk,
    output logic              rf_le
);

    typedef struct packed {
        logic err;
    } top_regs_t;

    top_regs_t t_d, t_q;
    frame_t    frame;
    logic      start;
    logic      busy;

    rf3w_framer u_framer (
        .rf_type (cmd_type),
        .addr    (cmd_addr),
        .data    (cmd_data),
        .frame   (frame)
    );

    assign start = cmd_valid && !busy && frame.known;

    rf3w_shifter #(
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame_i  (frame),
        .busy     (busy),
        .ser_clk  (rf_clk),
        .ser_data (rf_data),
        .ser_le   (rf_le)
    );

    always_comb begin
        t_d     = t_q;
        t_d.err = cmd_valid && !busy && !frame.known;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign poll_busy = busy;
    assign cmd_err   = t_q.err;

    // R6: a refused command never starts a transfer
    a_r6_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !poll_busy);
    a_r6_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !poll_busy && cmd_type[2]) |=> (!poll_busy && cmd_err));

    // R10: an accepted command sets the poll bit in the next cycle
    a_r10_poll_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !poll_busy && !cmd_type[2]) |=> (poll_busy && !cmd_err));

endmodule

// File: tb/rf3w_serializer_tb.sv
module rf3w_serializer_tb;

    localparam int HI = 3;
    localparam int LO = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_type = '0;
    logic [6:0]  cmd_addr = '0;
    logic [23:0] cmd_data = '0;
    logic        poll_busy, cmd_err, rf_data, rf_clk, rf_le;

    always #2 clk = ~clk;

    rf3w_serializer #(.HI_CYC(HI), .LO_CYC(LO)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_type  (cmd_type),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .poll_busy (poll_busy),
        .cmd_err   (cmd_err),
        .rf_data   (rf_data),
        .rf_clk    (rf_clk),
        .rf_le     (rf_le)
    );

    typedef struct {
        logic [31:0] w;
        int          n;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] r4(input logic [3:0] n);
        logic [3:0] o;
        for (int i = 0; i < 4; i++) o[3-i] = n[i];
        return o;
    endfunction

    function automatic item_t model(input int t, input logic [6:0] a, input logic [23:0] d);
        item_t it;
        logic [31:0] f;
        bit lsb;
        f = '0;
        lsb = 0;
        it.n = 0;
        it.tag = "";
        case (t)
            0: begin f = {16'h0, d[11:0], a[3:0]}; it.n = 16; it.tag = "R2"; end
            1: begin f = {d, 1'b1, a}; it.n = 32; lsb = 1; it.tag = "R3"; end
            2: begin
                f = {10'h0, 1'b0, r4(d[15:12]), a[0], r4(a[4:1]),
                     r4(d[3:0]), r4(d[7:4]), r4(d[11:8])};
                it.n = 22; it.tag = "R4";
            end
            default: begin f = {10'h0, d[17:0], a[3:0]}; it.n = 22; it.tag = "R5"; end
        endcase
        it.w = '0;
        if (lsb) begin
            for (int i = 0; i < it.n; i++) it.w[it.n-1-i] = f[i];
        end else begin
            it.w = f;
        end
        return it;
    endfunction

    // ---------------- monitor / scoreboard ----------------
    logic        prev_clk = 0, prev_le = 0, prev_dat = 0, prev_busy = 0;
    int          hi_len = 0, lo_len = 0, le_len = 0, ncap = 0;
    int          cyc = 0, le_fall_cyc = 0, rises = 0, le_count = 0;
    logic [31:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (rf_clk && !prev_clk) begin
                chk(lo_len >= LO, "R7 low phase", lo_len, LO);
                chk(rf_data == prev_dat, "R8 data at rise", rf_data, prev_dat);
                cap = {cap[30:0], rf_data};
                ncap++;
                rises++;
                hi_len = 1;
            end else if (rf_clk) begin
                hi_len++;
                chk(rf_data == prev_dat, "R8 data while high", rf_data, prev_dat);
            end
            if (!rf_clk && prev_clk) begin
                chk(hi_len == HI, "R7 high phase", hi_len, HI);
                lo_len = 1;
            end else if (!rf_clk) begin
                lo_len++;
            end
            if (rf_le && !prev_le) begin
                item_t it;
                le_count++;
                chk(!rf_clk, "R9 clk low at latch", rf_clk, 0);
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected frame", ncap, 0);
                end else begin
                    it = q.pop_front();
                    chk(ncap == it.n, {it.tag, " bit count"}, ncap, it.n);
                    chk(cap == it.w, {it.tag, " frame bits"}, cap, it.w);
                end
                cap = '0;
                ncap = 0;
                le_len = 1;
            end else if (rf_le) begin
                le_len++;
                if (rf_clk) chk(0, "R9 clk during latch", rf_clk, 0);
            end
            if (!rf_le && prev_le) begin
                chk(le_len == HI, "R9 latch width", le_len, HI);
                le_fall_cyc = cyc;
            end
            if (prev_busy && !poll_busy) begin
                chk(cyc - le_fall_cyc == LO, "R10 poll clear delay", cyc - le_fall_cyc, LO);
                chk(!rf_le && !rf_clk, "R9 latch low before next frame", rf_le, 0);
            end
            prev_clk  = rf_clk;
            prev_le   = rf_le;
            prev_dat  = rf_data;
            prev_busy = poll_busy;
        end
    end

    // ---------------- driver ----------------
    task automatic pulse(input int t, input logic [6:0] a, input logic [23:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_type  = 3'(t);
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send(input int t, input logic [6:0] a, input logic [23:0] d);
        q.push_back(model(t, a, d));
        pulse(t, a, d);
        chk(poll_busy == 1'b1, "R10 poll set after accept", poll_busy, 1);
        while (poll_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rf_clk == 0 && rf_data == 0 && rf_le == 0, "R1 serial idle", {rf_clk, rf_data, rf_le}, 0);
        chk(poll_busy == 0 && cmd_err == 0, "R1 status idle", {poll_busy, cmd_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(0, 7'h05, 24'h000ABC);      // R2
        send(0, 7'h7F, 24'hFFF000);      // R2 upper data ignored
        send(1, 7'h55, 24'h123456);      // R3
        send(1, 7'h00, 24'hFFFFFF);      // R3
        send(2, 7'h13, 24'h001234);      // R4
        send(2, 7'h1F, 24'h00FFFF);      // R4
        send(2, 7'h02, 24'h00C381);      // R4
        send(3, 7'h0A, 24'h02AAAA);      // R5
        send(3, 7'h05, 24'h3FFFF0);      // R5

        // R6: unknown type codes refused
        for (int t = 4; t < 8; t += 3) begin
            int r0, l0;
            r0 = rises;
            l0 = le_count;
            pulse(t, 7'h11, 24'h123456);
            chk(cmd_err == 1'b1, "R6 error pulse", cmd_err, 1);
            chk(poll_busy == 1'b0, "R6 no poll", poll_busy, 0);
            @(negedge clk);
            chk(cmd_err == 1'b0, "R6 single-cycle pulse", cmd_err, 0);
            repeat (20) @(negedge clk);
            chk(rises == r0 && le_count == l0, "R6 no activity", rises - r0, 0);
        end

        // R10: command during transfer ignored
        begin
            int l0;
            l0 = le_count;
            q.push_back(model(3, 7'h03, 24'h012345));
            pulse(3, 7'h03, 24'h012345);
            repeat (5) @(negedge clk);
            pulse(0, 7'h01, 24'h000777);
            while (poll_busy) @(negedge clk);
            repeat (40) @(negedge clk);
            chk(le_count == l0 + 1, "R10 busy command ignored", le_count - l0, 1);
            chk(poll_busy == 1'b0, "R10 poll stays clear", poll_busy, 0);
        end

        chk(q.size() == 0, "R2 all frames seen", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule